// File: doc/BRIEF.md
# SPI Controller With Double-Buffered Receive

This block is a serial peripheral port for an 8-bit microcontroller. Every transfer exchanges one byte in each direction at the same time: one byte leaves on the data-out line while another arrives on the data-in line, both timed by one serial clock. The block can act as the clock master, dividing the system clock by a programmable power of two, or as a slave that follows an external clock while its select pin is held low.

Transmit has a single buffer. A write to the data register loads the shift register directly and, in master mode, starts the transfer. Receive has two buffers. A completed byte is copied out of the shift path into a separate read buffer, so software can start the next exchange before it has collected the previous byte. Status flags report a completed byte, a byte lost to overrun, and a write that collided with a transfer still in progress. When the block is master or disabled, the select pin is not needed for selection and works as one general-purpose I/O bit.

Software sees four byte-wide registers, chosen by a 2-bit address. Address 0 is control: bit0 enable, bit1 master, bit2 clock idle level (CPOL), bit3 clock phase (CPHA), bits 6:4 divider code. Address 1 is status: bit0 byte ready, bit1 overrun, bit2 write collision, bit3 busy. Address 2 is data. Address 3 is the select-pin GPIO: bit0 is the output value on write and the synchronised pin level on read, bit1 is the output enable.

Top module: `spi_dbr_ctrl`

## Requirements
- R1: After reset, control, status, data and GPIO enable read as zero, GPIO bit0 reads the synchronised select-pin level, and sck_oe, mosi_oe, miso_oe and ss_oe are low.
- R2: In master mode, a data write while idle produces exactly 8 clock pulses. Each half period lasts 2^code system clocks, where code is control bits 6:4, and the clock rests at the CPOL level whenever no transfer is running.
- R3: Data goes out MSB first. With CPHA=0, each bit is valid before the leading clock edge and is sampled on that edge. With CPHA=1, each bit changes on the leading edge and is sampled on the trailing edge. The leading edge is the transition away from CPOL.
- R4: The 8 bits sampled from miso_i (master) or mosi_i (slave), MSB first, are placed in the read buffer, and status bit0 is set.
- R5: A new transfer may start while status bit0 is still set. Until that transfer completes, the read buffer keeps returning the earlier byte.
- R6: If a byte completes while status bit0 is still set, status bit1 (overrun) is set, the new byte is discarded and the unread byte is kept.
- R7: A data write while busy sets status bit2 and changes neither the byte being shifted nor the transfer.
- R8: Reading address 2 clears status bit0. Writing 1 to status bit1 or bit2 clears that flag.
- R9: In slave mode, the block shifts only while ss_i is low. miso_oe is high only while the block is enabled as slave and selected, and miso_o carries the loaded byte MSB first.
- R10: In slave mode, raising ss_i in the middle of a byte drops miso_oe, completes no byte and restarts the bit count, so the next full byte is received correctly.
- R11: When the block is master or disabled, ss_o and ss_oe follow GPIO bits 0 and 1. When the block is an enabled slave, ss_oe is low.
- R12: While the block is disabled, a data write starts no transfer. The serial clock does not toggle, status stays clear, and sck_oe and mosi_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock drive enable |
| mosi_i | input | 1 | Master-out line, slave receive |
| mosi_o | output | 1 | Master-out line, master drive |
| mosi_oe | output | 1 | Master-out drive enable |
| miso_i | input | 1 | Master-in line, master receive |
| miso_o | output | 1 | Master-in line, slave drive |
| miso_oe | output | 1 | Master-in drive enable |
| ss_i | input | 1 | Select pin level |
| ss_o | output | 1 | Select pin GPIO output value |
| ss_oe | output | 1 | Select pin GPIO drive enable |

## Verification
The bench builds the block with its default parameters: a 3-bit divider code, 8-bit transfers and a two-stage synchroniser on the slave inputs. Divider codes 0, 1 and 2 are exercised. Code 0 gives a one-clock half period, so a clock edge fires on every system cycle and tests the tightest master timing. In slave mode the bench holds each serial half period for 8 system clocks, which stays well clear of the two-cycle synchroniser delay. All four CPOL and CPHA combinations are covered between the master and slave runs.

// File: rtl/spi_dbr_pkg.sv
`timescale 1ns/1ps
// Package: shared register layout and widths for the SPI controller.
// Assumes one byte-wide register file decoded by a 2-bit address.
package spi_dbr_pkg;
    parameter int REG_W   = 8;   // register and transfer width
    parameter int DIV_W   = 3;   // divider code width
    parameter int ADDR_W  = 2;   // register address width

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_DATA = 2'd2,
        A_PIO  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             spare;
        logic [DIV_W-1:0] div;
        logic             cpha;
        logic             cpol;
        logic             master;
        logic             en;
    } ctrl_t;

    localparam int ST_READY = 0;
    localparam int ST_OVR   = 1;
    localparam int ST_WCOL  = 2;
    localparam int ST_BUSY  = 3;
endpackage

// File: rtl/spi_clkgen.sv
`timescale 1ns/1ps
// Module: master serial-clock tick generator.
// While run is high it emits a one-cycle tick every 2^sel system clocks;
// each tick marks one serial clock edge. Counter clears whenever run is low.
module spi_clkgen #(
    parameter int DIV_W = spi_dbr_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = 2 ** DIV_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    // Terminal count: half period minus one.
    always_comb begin
        half_m1 = (CNT_W'(1) << sel) - CNT_W'(1);
    end

    // Count system clocks within one serial half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == half_m1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign tick = run && (cnt == half_m1);

    // R2: with a half period above one clock, edges are never back to back
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != '0) |=> !tick);
endmodule

// File: rtl/spi_shifter.sv
`timescale 1ns/1ps
// Module: shared shift engine for master and slave.
// Counts serial clock edges (two per bit). Sampling and shifting alternate
// according to CPHA. Transmit and receive use separate registers. Assumes
// load only arrives between bytes, and abort clears the edge count.
module spi_shifter #(
    parameter int BITS = spi_dbr_pkg::REG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_stb,
    input  logic            abort,
    input  logic            cpha,
    input  logic            load,
    input  logic [BITS-1:0] load_data,
    input  logic            rx_bit,
    output logic            tx_msb,
    output logic [BITS-1:0] rx_byte,
    output logic            rx_done,
    output logic            last_edge,
    output logic            mid_byte
);
    localparam int EDGES = 2 * BITS;
    localparam int EW    = $clog2(EDGES);

    logic [EW-1:0]   edge_cnt;
    logic [BITS-1:0] tx_sr;
    logic [BITS-1:0] rx_sr;
    logic            sample_now;
    logic            shift_now;

    // Decide what this edge does: sample on the CPHA-selected edge parity.
    always_comb begin
        sample_now = edge_stb && (edge_cnt[0] == cpha);
        shift_now  = edge_stb && !sample_now && !(cpha && edge_cnt == '0);
    end

    // Edge counter: wraps after the last edge of a byte, cleared by abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            edge_cnt <= '0;
        end else if (edge_stb) begin
            edge_cnt <= (edge_cnt == EW'(EDGES - 1)) ? '0 : edge_cnt + EW'(1);
        end
    end

    // Transmit register: parallel load, else shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_data;
        end else if (shift_now) begin
            tx_sr <= {tx_sr[BITS-2:0], 1'b0};
        end
    end

    // Receive register: collect sampled bits MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (sample_now) begin
            rx_sr <= {rx_sr[BITS-2:0], rx_bit};
        end
    end

    assign tx_msb    = tx_sr[BITS-1];
    assign rx_byte   = {rx_sr[BITS-2:0], rx_bit};
    assign rx_done   = sample_now && ((edge_cnt >> 1) == EW'(BITS - 1));
    assign last_edge = edge_stb && (edge_cnt == EW'(EDGES - 1));
    assign mid_byte  = (edge_cnt != '0);

    // R10: a deselect leaves the engine at the start of a byte
    p_abort_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !mid_byte);
    // R3: the transmit register never moves on a sampling edge
    p_no_shift_on_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_now && !load) |=> $stable(tx_msb));
endmodule

// File: rtl/spi_rxbuf.sv
`timescale 1ns/1ps
// Module: receive read buffer with ready and overrun flags.
// Accepts a byte on capture. If the previous byte is still unread, the new
// byte is dropped and overrun is raised. A read clears ready.
module spi_rxbuf #(
    parameter int BITS = spi_dbr_pkg::REG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [BITS-1:0] cap_byte,
    input  logic            rd_take,
    input  logic            ovr_clr,
    output logic [BITS-1:0] rbuf,
    output logic            full,
    output logic            ovr
);
    // Hold the latest accepted byte and its ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf <= '0;
            full <= 1'b0;
        end else if (capture && (!full || rd_take)) begin
            rbuf <= cap_byte;
            full <= 1'b1;
        end else if (rd_take) begin
            full <= 1'b0;
        end
    end

    // Overrun: set by a completion against an unread byte, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
        end else if (capture && full && !rd_take) begin
            ovr <= 1'b1;
        end else if (ovr_clr) begin
            ovr <= 1'b0;
        end
    end

    // R6: an unread byte stays ready and unchanged until it is read
    p_keep_unread_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_take) |=> (full && $stable(rbuf)));
    // R6: overrun only rises against a ready byte
    p_ovr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(full));
endmodule

// File: rtl/spi_dbr_ctrl.sv
`timescale 1ns/1ps
// Module: SPI controller top, with register file, master sequencing,
// slave input synchronisers and select-pin GPIO.
// Assumes: miso_i in master mode is timed by the block's own clock, so it
// is sampled directly; slave inputs are asynchronous and pass through
// SYNC_STAGES flops; bus_rdata is combinational and bus_rd only adds side effects.
module spi_dbr_ctrl #(
    parameter int BITS        = spi_dbr_pkg::REG_W,
    parameter int DIV_W       = spi_dbr_pkg::DIV_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [spi_dbr_pkg::ADDR_W-1:0] bus_addr,
    input  logic [BITS-1:0]                bus_wdata,
    output logic [BITS-1:0]                bus_rdata,
    input  logic                           sck_i,
    output logic                           sck_o,
    output logic                           sck_oe,
    input  logic                           mosi_i,
    output logic                           mosi_o,
    output logic                           mosi_oe,
    input  logic                           miso_i,
    output logic                           miso_o,
    output logic                           miso_oe,
    input  logic                           ss_i,
    output logic                           ss_o,
    output logic                           ss_oe
);
    import spi_dbr_pkg::*;

    ctrl_t                  ctrl_q;
    logic                   pio_out_q, pio_oe_q, wcol_q;
    logic                   m_busy, m_phase, m_tick;
    logic [SYNC_STAGES-1:0] sck_s, mosi_s, ss_s;
    logic                   sck_prev;
    logic                   is_master, is_slave, selected, busy;
    logic                   wr_data, wr_ctrl, wr_stat, wr_pio, rd_take;
    logic                   start_ok, edge_stb, abort, rx_bit;
    logic                   tx_msb, rx_done, last_edge, mid_byte;
    logic [BITS-1:0]        rx_byte, rbuf;
    logic                   rx_full, rx_ovr;
    logic                   sck_sync, mosi_sync, ss_sync;

    // Register access decode.
    always_comb begin
        wr_ctrl = bus_wr && bus_addr == A_CTRL;
        wr_stat = bus_wr && bus_addr == A_STAT;
        wr_data = bus_wr && bus_addr == A_DATA;
        wr_pio  = bus_wr && bus_addr == A_PIO;
        rd_take = bus_rd && bus_addr == A_DATA;
    end

    // Bring the slave-side pins into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s  <= '0;
            mosi_s <= '0;
            ss_s   <= '1;
        end else begin
            sck_s  <= {sck_s[SYNC_STAGES-2:0], sck_i};
            mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi_i};
            ss_s   <= {ss_s[SYNC_STAGES-2:0], ss_i};
        end
    end

    assign sck_sync  = sck_s[SYNC_STAGES-1];
    assign mosi_sync = mosi_s[SYNC_STAGES-1];
    assign ss_sync   = ss_s[SYNC_STAGES-1];

    // Remember the last synchronised serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_sync;
    end

    // Mode, selection and transfer-start decisions.
    always_comb begin
        is_master = ctrl_q.en && ctrl_q.master;
        is_slave  = ctrl_q.en && !ctrl_q.master;
        selected  = is_slave && !ss_sync;
        busy      = m_busy || (selected && mid_byte);
        start_ok  = wr_data && ctrl_q.en && !busy;
        edge_stb  = is_master ? m_tick : (selected && (sck_sync != sck_prev));
        abort     = !(m_busy || selected);
        rx_bit    = is_master ? miso_i : mosi_sync;
    end

    // Control and GPIO registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            pio_out_q <= 1'b0;
            pio_oe_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
            if (wr_pio) begin
                pio_out_q <= bus_wdata[0];
                pio_oe_q  <= bus_wdata[1];
            end
        end
    end

    // Write-collision flag: set by a data write during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcol_q <= 1'b0;
        end else if (wr_data && ctrl_q.en && busy) begin
            wcol_q <= 1'b1;
        end else if (wr_stat && bus_wdata[ST_WCOL]) begin
            wcol_q <= 1'b0;
        end
    end

    // Master sequencing: busy from start to the final edge; phase toggles per edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !is_master) begin
            m_busy  <= 1'b0;
            m_phase <= 1'b0;
        end else if (start_ok) begin
            m_busy  <= 1'b1;
            m_phase <= 1'b0;
        end else if (m_tick) begin
            m_phase <= !m_phase;
            if (last_edge) m_busy <= 1'b0;
        end
    end

    spi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (m_busy),
        .sel   (ctrl_q.div),
        .tick  (m_tick)
    );

    spi_shifter #(.BITS(BITS)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_stb  (edge_stb),
        .abort     (abort),
        .cpha      (ctrl_q.cpha),
        .load      (start_ok),
        .load_data (bus_wdata),
        .rx_bit    (rx_bit),
        .tx_msb    (tx_msb),
        .rx_byte   (rx_byte),
        .rx_done   (rx_done),
        .last_edge (last_edge),
        .mid_byte  (mid_byte)
    );

    spi_rxbuf #(.BITS(BITS)) u_rxbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rx_done),
        .cap_byte (rx_byte),
        .rd_take  (rd_take),
        .ovr_clr  (wr_stat && bus_wdata[ST_OVR]),
        .rbuf     (rbuf),
        .full     (rx_full),
        .ovr      (rx_ovr)
    );

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = BITS'(ctrl_q);
            A_STAT: begin
                bus_rdata[ST_READY] = rx_full;
                bus_rdata[ST_OVR]   = rx_ovr;
                bus_rdata[ST_WCOL]  = wcol_q;
                bus_rdata[ST_BUSY]  = busy;
            end
            A_DATA: bus_rdata = rbuf;
            default: begin
                bus_rdata[0] = ss_sync;
                bus_rdata[1] = pio_oe_q;
            end
        endcase
    end

    // Pin drivers.
    assign sck_o   = ctrl_q.cpol ^ m_phase;
    assign sck_oe  = is_master;
    assign mosi_o  = tx_msb;
    assign mosi_oe = is_master;
    assign miso_o  = tx_msb;
    assign miso_oe = selected;
    assign ss_o    = pio_out_q;
    assign ss_oe   = pio_oe_q && !is_slave;

    // R2: the master clock rests at its idle level outside a transfer
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !m_busy) |-> (sck_o == ctrl_q.cpol));
    // R4: the ready flag only rises when the shift engine finishes a byte
    p_ready_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(rx_done));
    // R7: a collision can only be flagged while a transfer is running
    p_wcol_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol_q) |-> $past(busy));
    // R11: the select pin is never driven while it serves as a slave select
    p_ss_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
        selected |-> !ss_oe);
    // R12: disabling the block stops any master transfer
    p_off_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |=> !m_busy);
endmodule

// File: tb/spi_dbr_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: behavioural model of the register state plus a serial partner on
// the pins. Pin enables are compared against the model on every clock.
module spi_dbr_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0, bus_rdata;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_i = 1'b1;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;

    int   errors = 0;
    int   checks = 0;
    logic mon_on = 1'b0;
    logic finished = 1'b0;
    logic [7:0] ctrl_m = 8'h00;
    logic [7:0] pio_m  = 8'h00;

    always #2 clk = ~clk; // 250 MHz

    spi_dbr_ctrl u_spi_dbr_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        if (a == 2'd0) ctrl_m = d;
        if (a == 2'd3) pio_m = {6'd0, d[1:0]};
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        bus_read(a, v);
        check(v == exp, req, v, exp);
    endtask

    // Per-clock comparison of the pin enables with the modelled registers (R11, R12).
    always @(negedge clk) begin
        if (mon_on) begin
            automatic logic m_en = ctrl_m[0] && ctrl_m[1];
            automatic logic s_en = ctrl_m[0] && !ctrl_m[1];
            check(sck_oe == m_en && mosi_oe == m_en, "R12 pin enables",
                  {sck_oe, mosi_oe}, {m_en, m_en});
            check(ss_oe == (pio_m[1] && !s_en), "R11 ss_oe", ss_oe, pio_m[1] && !s_en);
            if (ss_oe) check(ss_o == pio_m[0], "R11 ss_o", ss_o, pio_m[0]);
        end
    end

    // Master transfer with the bench acting as the far-end slave.
    // mode: 0 plain, 1 colliding write at edge 5, 2 data read at edge 5.
    task automatic master_xfer(input logic [7:0] txb, input logic [7:0] rxb,
                               input logic cpol, input logic cpha, input int div,
                               input int mode, output logic [7:0] mid_val);
        int edges = 0, t = 0, t0 = 0;
        logic prev;
        logic hook = 1'b0;
        mid_val = 8'h00;
        bus_write(2'd0, {1'b0, 3'(div), cpha, cpol, 1'b1, 1'b1});
        miso_i = rxb[7];
        check(sck_o == cpol, "R2 idle level before", sck_o, cpol);
        bus_write(2'd2, txb);
        prev = sck_o;
        while (edges < 16 && t < 4000) begin
            @(negedge clk);
            t++;
            if (hook) begin bus_wr = 1'b0; bus_rd = 1'b0; hook = 1'b0; end
            if (sck_o != prev) begin
                prev = sck_o;
                if (edges == 0) t0 = t;
                if (edges == 1) check(t - t0 == (1 << div), "R2 half period", t - t0, 1 << div);
                if ((edges % 2) == int'(cpha)) begin
                    check(mosi_o == txb[7 - edges / 2], "R3 mosi bit", mosi_o, txb[7 - edges / 2]);
                end else begin
                    automatic int nb = cpha ? edges / 2 : (edges + 1) / 2;
                    if (nb < 8) miso_i = rxb[7 - nb];
                end
                edges++;
                if (edges == 5 && mode == 1) begin
                    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = ~txb; hook = 1'b1;
                end
                if (edges == 5 && mode == 2) begin
                    bus_rd = 1'b1; bus_addr = 2'd2; hook = 1'b1;
                    #1 mid_val = bus_rdata;
                end
            end
        end
        if (hook) begin @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0; end
        check(edges == 16, "R2 edge count", edges, 16);
        repeat (4) @(negedge clk);
        check(sck_o == cpol, "R2 idle level after", sck_o, cpol);
    endtask

    // Slave transfer with the bench driving clock, select and mosi; H clocks per half period.
    task automatic slave_xfer(input logic [7:0] mb, input logic [7:0] txb, input logic cpol,
                              input logic cpha, input int nbits, input bit chk_miso);
        localparam int H = 8;
        sck_i = cpol;
        repeat (4) @(negedge clk);
        ss_i = 1'b0;
        repeat (H) @(negedge clk);
        check(miso_oe == 1'b1, "R9 miso_oe selected", miso_oe, 1);
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) begin
                mosi_i = mb[7 - i];
                repeat (H) @(negedge clk);
                if (chk_miso) check(miso_o == txb[7 - i], "R9 miso bit cpha0", miso_o, txb[7 - i]);
                sck_i = !cpol;
                repeat (H) @(negedge clk);
                sck_i = cpol;
            end else begin
                sck_i = !cpol;
                repeat (2) @(negedge clk);
                mosi_i = mb[7 - i];
                repeat (H - 2) @(negedge clk);
                if (chk_miso) check(miso_o == txb[7 - i], "R9 miso bit cpha1", miso_o, txb[7 - i]);
                sck_i = cpol;
                repeat (H) @(negedge clk);
            end
        end
        repeat (H) @(negedge clk);
        ss_i = 1'b1;
        repeat (6) @(negedge clk);
        check(miso_oe == 1'b0, "R9 R10 miso_oe released", miso_oe, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] mv;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        check({sck_oe, mosi_oe, miso_oe, ss_oe} == 4'b0, "R1 enables", {sck_oe, mosi_oe, miso_oe, ss_oe}, 0);
        expect_reg(2'd0, 8'h00, "R1 ctrl");
        expect_reg(2'd1, 8'h00, "R1 status");
        expect_reg(2'd2, 8'h00, "R1 data");
        expect_reg(2'd3, 8'h01, "R1 pio");
        mon_on = 1'b1;

        // R2 R3 R4 R8: master across modes and dividers
        master_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 0, 0, mv);
        expect_reg(2'd1, 8'h01, "R4 ready set");
        expect_reg(2'd2, 8'h3C, "R4 byte mode0");
        expect_reg(2'd1, 8'h00, "R8 ready cleared by read");
        master_xfer(8'h81, 8'h7E, 1'b1, 1'b1, 1, 0, mv);
        expect_reg(2'd2, 8'h7E, "R4 byte mode3");
        master_xfer(8'h5A, 8'hC3, 1'b0, 1'b1, 2, 0, mv);
        expect_reg(2'd2, 8'hC3, "R4 byte mode1");
        master_xfer(8'h0F, 8'hF0, 1'b1, 1'b0, 0, 0, mv);
        expect_reg(2'd2, 8'hF0, "R4 byte mode2");

        // R5: next transfer starts with the previous byte unread
        master_xfer(8'h11, 8'h22, 1'b0, 1'b0, 1, 0, mv);
        master_xfer(8'h33, 8'h44, 1'b0, 1'b0, 1, 2, mv);
        check(mv == 8'h22, "R5 old byte during transfer", mv, 8'h22);
        expect_reg(2'd1, 8'h01, "R5 no overrun");
        expect_reg(2'd2, 8'h44, "R5 new byte");

        // R6 R8: overrun keeps the unread byte
        master_xfer(8'h01, 8'h55, 1'b0, 1'b0, 0, 0, mv);
        master_xfer(8'h02, 8'h66, 1'b0, 1'b0, 0, 0, mv);
        expect_reg(2'd1, 8'h03, "R6 overrun flagged");
        expect_reg(2'd2, 8'h55, "R6 old byte kept");
        expect_reg(2'd1, 8'h02, "R8 ready cleared, overrun kept");
        bus_write(2'd1, 8'h02);
        expect_reg(2'd1, 8'h00, "R8 overrun cleared by write-one");

        // R7: colliding write flagged, bits unchanged (mosi checked in the transfer)
        master_xfer(8'h9C, 8'h00, 1'b0, 1'b0, 1, 1, mv);
        expect_reg(2'd1, 8'h05, "R7 collision flagged");
        expect_reg(2'd2, 8'h00, "R7 received byte");
        bus_write(2'd1, 8'h04);
        expect_reg(2'd1, 8'h00, "R8 collision cleared");

        // R12: disabled block ignores data writes
        bus_write(2'd0, 8'h00);
        bus_write(2'd2, 8'h77);
        begin
            automatic int toggles = 0;
            automatic logic p = sck_o;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (sck_o != p) toggles++;
                p = sck_o;
            end
            check(toggles == 0, "R12 no clock", toggles, 0);
        end
        expect_reg(2'd1, 8'h00, "R12 status idle");

        // R11: select pin as GPIO
        bus_write(2'd3, 8'h03);
        check(ss_oe == 1'b1 && ss_o == 1'b1, "R11 gpio drive", {ss_oe, ss_o}, 2'b11);
        bus_write(2'd3, 8'h02);
        ss_i = 1'b0;
        repeat (4) @(negedge clk);
        expect_reg(2'd3, 8'h02, "R11 pin readback");
        ss_i = 1'b1;
        bus_write(2'd0, 8'h01);
        check(ss_oe == 1'b0, "R11 slave releases pin", ss_oe, 0);
        bus_write(2'd0, 8'h03);
        check(ss_oe == 1'b1, "R11 master drives pin", ss_oe, 1);
        bus_write(2'd3, 8'h00);

        // R9 R4: slave, CPOL=0 CPHA=0
        bus_write(2'd0, 8'h01);
        repeat (2) @(negedge clk);
        check(miso_oe == 1'b0, "R9 miso_oe deselected", miso_oe, 0);
        bus_write(2'd2, 8'hB4);
        slave_xfer(8'h6D, 8'hB4, 1'b0, 1'b0, 8, 1'b1);
        expect_reg(2'd1, 8'h01, "R4 slave ready");
        expect_reg(2'd2, 8'h6D, "R4 slave byte cpha0");

        // R9 R4: slave, CPOL=1 CPHA=1
        bus_write(2'd0, 8'h0D);
        bus_write(2'd2, 8'h2E);
        slave_xfer(8'hD1, 8'h2E, 1'b1, 1'b1, 8, 1'b1);
        expect_reg(2'd2, 8'hD1, "R4 slave byte cpha1");

        // R10: deselect mid-byte, then a full byte
        bus_write(2'd0, 8'h01);
        bus_write(2'd2, 8'hFF);
        slave_xfer(8'hE0, 8'hFF, 1'b0, 1'b0, 3, 1'b1);
        expect_reg(2'd1, 8'h00, "R10 no byte after abort");
        slave_xfer(8'h96, 8'h00, 1'b0, 1'b0, 8, 1'b0);
        expect_reg(2'd1, 8'h01, "R10 ready after full byte");
        expect_reg(2'd2, 8'h96, "R10 byte after restart");

        mon_on = 1'b0;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule